// File: doc/BRIEF.md
# Row-Buffered Single-Bit Dynamic Memory Array

This block models a one-bit-wide dynamic memory whose every access passes through a bank of column latches. A row is opened with the row strobe: the whole row is copied from the storage array into the latches. Column strobes then read or write single bits of that latched row. One row open, several column accesses (page mode) costs a single activation. A nibble-mode read returns four bits on back-to-back cycles. The block produces the three further column addresses itself, and they wrap inside an aligned group of four.

The latched row goes back to the array when the row is closed (precharge) or, for a closed bank, when a refresh command reads a row into the latches and writes it back on the next cycle. An internal interval counter raises a refresh-request output a set number of cycles after reset or after the last accepted refresh. The request stays up until a refresh is accepted. The storage is a plain register array with no decay. Electrical timing is not modelled.

The address bus is shared. With the row strobe it carries the row number in its low ROW_BITS bits. With the column strobe it carries the column number in its low COL_BITS bits. A full address is therefore the row number above the column number.

Top module: `dram_rowbuf`

## Requirements
- R1: A row strobe on a closed bank loads row `addr_i[ROW_BITS-1:0]` into the latches and opens it. A column read (`cas_i`=1, `we_i`=0, `nib_i`=0) then drives the bit of column `addr_i[COL_BITS-1:0]` on `dout_o`, with `dvalid_o`=1, on the cycle after the strobe.
- R2: A column write (`cas_i`=1, `we_i`=1) to an open row stores `din_i` into the selected latch and gives `dvalid_o`=0. A later read of that column in the same open row returns the written bit.
- R3: While a row is open, successive column strobes address new columns of that row without any new row activation.
- R4: A nibble read (`cas_i`=1, `we_i`=0, `nib_i`=1) at column c yields four valid bits on four consecutive cycles, starting the cycle after the strobe. The bits come from columns whose upper bits equal those of c and whose low two bits are c+0, c+1, c+2 and c+3 modulo 4.
- R5: All strobes that arrive while a nibble burst or a refresh write-back is in progress are ignored.
- R6: A precharge (`pre_i`) writes the latches back to the open row and closes it. Reopening that row later returns any bits written before the precharge.
- R7: A refresh (`ref_i`) on a closed bank reads row `addr_i[ROW_BITS-1:0]` into the latches and writes it back on the next cycle, leaving its contents unchanged. A refresh while a row is open is ignored and leaves the refresh request unchanged.
- R8: With interval N > 0, `ref_req_o` rises N cycles after the end of reset or after an accepted refresh, and stays high until a refresh is accepted. N = 0 never raises it.
- R9: `dvalid_o` is high exactly on cycles on which `dout_o` carries a selected bit, and is low otherwise.
- R10: A column strobe on a closed bank, or a row strobe while a row is open, is ignored and sets `err_o` for one cycle.
- R11: Only the highest-priority strobe asserted in a cycle is considered, in the order refresh, precharge, row, column. The lower ones are dropped even when the higher one is itself ignored.
- R12: After reset the bank is closed and `dout_o`, `dvalid_o`, `err_o` and `ref_req_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_i | input | 1 | Row strobe: open the row on `addr_i` |
| cas_i | input | 1 | Column strobe: access the column on `addr_i` |
| we_i | input | 1 | With `cas_i`: write instead of read |
| nib_i | input | 1 | With a column read: four-bit nibble burst |
| pre_i | input | 1 | Precharge: write back and close the open row |
| ref_i | input | 1 | Refresh the row on `addr_i` (bank closed) |
| addr_i | input | max(ROW_BITS,COL_BITS) | Multiplexed row / column address |
| din_i | input | 1 | Write data |
| ref_interval_i | input | CNT_W | Cycles between refresh requests, 0 disables |
| dout_o | output | 1 | Read data |
| dvalid_o | output | 1 | `dout_o` carries a selected bit |
| err_o | output | 1 | One-cycle flag for a strobe in the wrong bank state |
| ref_req_o | output | 1 | Refresh is due |

## Verification
The bench builds the block with ROW_BITS=4 and COL_BITS=5, which gives 16 rows of 32 columns. At that size the bench can write every bit of the array first, so every later read has a known expected value. Random row opens, page accesses, nibble bursts and precharges then revisit rows often, which exercises write-back across reopen. Five column bits leave room for several aligned nibble groups, so wrap from the middle of a group is seen at several offsets. An 8-bit interval counter set to 20 lets the bench watch the refresh request rise at its exact cycle and hold across a refresh that is ignored.

// File: rtl/dram_pkg.sv
// Shared types for the row-buffered memory.
// Assumes nothing beyond IEEE 1800-2017 packages.
package dram_pkg;

    // Bank sequencing states.
    typedef enum logic [1:0] {
        ST_CLOSED = 2'd0,
        ST_OPEN   = 2'd1,
        ST_BURST  = 2'd2,
        ST_REFWB  = 2'd3
    } dram_state_t;

    // Larger of two widths, used to size the shared address bus.
    function automatic int unsigned wmax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_cell_array.sv
// Storage array: ROWS words of COLS bits, one whole-row read port and
// one whole-row write port. The read is combinational from the row index.
// Assumes the caller never needs the written row on the same cycle.
// Contents are not reset: it models data storage.
module dram_cell_array #(
    parameter int unsigned ROW_BITS = 6,
    parameter int unsigned COL_BITS = 6
) (
    input  logic                        clk,
    input  logic [ROW_BITS-1:0]         rd_row,
    output logic [(1<<COL_BITS)-1:0]    rd_data,
    input  logic                        wr_en,
    input  logic [ROW_BITS-1:0]         wr_row,
    input  logic [(1<<COL_BITS)-1:0]    wr_data
);
    localparam int unsigned ROWS = 1 << ROW_BITS;
    localparam int unsigned COLS = 1 << COL_BITS;

    logic [COLS-1:0] mem [ROWS];

    // Write a whole row back into storage.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_row] <= wr_data;
    end

    // Row read feeding the column latches.
    assign rd_data = mem[rd_row];

endmodule

// File: rtl/dram_col_latch.sv
// Column latch bank with the column multiplexer and the registered output.
// Load copies a whole row; a write updates one latch; a read registers the
// selected latch onto dout with dvalid. Load has priority over write.
module dram_col_latch #(
    parameter int unsigned COL_BITS = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [(1<<COL_BITS)-1:0]    load_data,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [COL_BITS-1:0]         col,
    input  logic                        din,
    output logic [(1<<COL_BITS)-1:0]    latches,
    output logic                        dout,
    output logic                        dvalid
);
    localparam int unsigned COLS = 1 << COL_BITS;

    // Latch bank: full-row load or single-bit update.
    always_ff @(posedge clk) begin
        if (load)       latches      <= load_data;
        else if (wr_en) latches[col] <= din;
    end

    // Column multiplexer and registered data output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout   <= 1'b0;
            dvalid <= 1'b0;
        end else begin
            dvalid <= rd_en;
            dout   <= rd_en ? latches[col] : 1'b0;
        end
    end

endmodule

// File: rtl/dram_ref_timer.sv
// Refresh interval counter. Raises req `interval` cycles after reset or
// after an acknowledge; holds it until acknowledged. Interval 0 disables.
module dram_ref_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  interval,
    input  logic              ack,
    output logic              req
);
    logic [CNT_W-1:0] cnt;

    // Count cycles up to the interval and latch the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            req <= 1'b0;
        end else if (ack) begin
            cnt <= '0;
            req <= 1'b0;
        end else if (interval != '0 && !req) begin
            if (cnt == interval - 1'b1) req <= 1'b1;
            else                        cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dram_ctrl.sv
// Bank sequencer: decodes strobes by priority (refresh, precharge, row,
// column), tracks the open row, runs nibble bursts and refresh write-back.
// Assumes COL_BITS >= 2 so an aligned group of four columns exists.
module dram_ctrl
    import dram_pkg::*;
#(
    parameter int unsigned ROW_BITS = 6,
    parameter int unsigned COL_BITS = 6,
    parameter int unsigned ADDR_W   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ras_i,
    input  logic                 cas_i,
    input  logic                 we_i,
    input  logic                 nib_i,
    input  logic                 pre_i,
    input  logic                 ref_i,
    input  logic [ADDR_W-1:0]    addr_i,
    output logic                 lat_load,
    output logic                 lat_wr,
    output logic                 lat_rd,
    output logic [COL_BITS-1:0]  lat_col,
    output logic [ROW_BITS-1:0]  arr_rd_row,
    output logic                 arr_wr,
    output logic [ROW_BITS-1:0]  arr_wr_row,
    output logic                 ref_ack,
    output logic                 err,
    output logic                 row_open,
    output logic                 busy
);
    dram_state_t          state;
    logic [ROW_BITS-1:0]  cur_row;
    logic [COL_BITS-1:0]  bcol;
    logic [1:0]           bidx;

    logic is_closed, is_open, sel_ras, sel_cas;
    logic do_ref, do_pre, do_act, do_wr, do_rd, do_nib, bad_cmd;

    // Strobe priority and acceptance decode.
    always_comb begin
        is_closed = (state == ST_CLOSED);
        is_open   = (state == ST_OPEN);
        sel_ras   = ras_i && !pre_i && !ref_i;
        sel_cas   = cas_i && !ras_i && !pre_i && !ref_i;
        do_ref    = ref_i && is_closed;
        do_pre    = pre_i && !ref_i && is_open;
        do_act    = sel_ras && is_closed;
        do_wr     = sel_cas && we_i && is_open;
        do_rd     = sel_cas && !we_i && !nib_i && is_open;
        do_nib    = sel_cas && !we_i && nib_i && is_open;
        bad_cmd   = (sel_ras && is_open) || (sel_cas && is_closed);
    end

    // Datapath controls for the array and the latch bank.
    always_comb begin
        lat_load   = do_act || do_ref;
        lat_wr     = do_wr;
        lat_rd     = do_rd || do_nib || (state == ST_BURST);
        lat_col    = (state == ST_BURST)
                   ? {bcol[COL_BITS-1:2], bcol[1:0] + bidx}
                   : addr_i[COL_BITS-1:0];
        arr_rd_row = addr_i[ROW_BITS-1:0];
        arr_wr     = do_pre || (state == ST_REFWB);
        arr_wr_row = cur_row;
        ref_ack    = do_ref;
        row_open   = (state == ST_OPEN) || (state == ST_BURST);
        busy       = (state == ST_BURST) || (state == ST_REFWB);
    end

    // State sequencing, open-row and burst bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_CLOSED;
            cur_row <= '0;
            bcol    <= '0;
            bidx    <= '0;
        end else begin
            unique case (state)
                ST_CLOSED: begin
                    if (do_ref) begin
                        state   <= ST_REFWB;
                        cur_row <= addr_i[ROW_BITS-1:0];
                    end else if (do_act) begin
                        state   <= ST_OPEN;
                        cur_row <= addr_i[ROW_BITS-1:0];
                    end
                end
                ST_OPEN: begin
                    if (do_pre) begin
                        state <= ST_CLOSED;
                    end else if (do_nib) begin
                        state <= ST_BURST;
                        bcol  <= addr_i[COL_BITS-1:0];
                        bidx  <= 2'd1;
                    end
                end
                ST_BURST: begin
                    bidx <= bidx + 2'd1;
                    if (bidx == 2'd3) state <= ST_OPEN;
                end
                ST_REFWB: state <= ST_CLOSED;
                default:  state <= ST_CLOSED;
            endcase
        end
    end

    // One-cycle error flag for strobes in the wrong bank state.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= bad_cmd;
    end

endmodule

// File: rtl/dram_rowbuf.sv
// Top: single-bit dynamic memory with column latches, page and nibble
// modes, precharge and refresh write-back, and a refresh-request timer.
// Assumes one strobe set per cycle; priority settles conflicts.
module dram_rowbuf
    import dram_pkg::*;
#(
    parameter int unsigned ROW_BITS = 6,
    parameter int unsigned COL_BITS = 6,
    parameter int unsigned CNT_W    = 16,
    localparam int unsigned ADDR_W  = wmax(ROW_BITS, COL_BITS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ras_i,
    input  logic               cas_i,
    input  logic               we_i,
    input  logic               nib_i,
    input  logic               pre_i,
    input  logic               ref_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               din_i,
    input  logic [CNT_W-1:0]   ref_interval_i,
    output logic               dout_o,
    output logic               dvalid_o,
    output logic               err_o,
    output logic               ref_req_o
);
    localparam int unsigned COLS = 1 << COL_BITS;

    logic                lat_load, lat_wr, lat_rd, arr_wr, ref_ack;
    logic                row_open, busy;
    logic [COL_BITS-1:0] lat_col;
    logic [ROW_BITS-1:0] arr_rd_row, arr_wr_row;
    logic [COLS-1:0]     arr_rd_data, latches;

    dram_ctrl #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ras_i(ras_i), .cas_i(cas_i), .we_i(we_i), .nib_i(nib_i),
        .pre_i(pre_i), .ref_i(ref_i), .addr_i(addr_i),
        .lat_load(lat_load), .lat_wr(lat_wr), .lat_rd(lat_rd), .lat_col(lat_col),
        .arr_rd_row(arr_rd_row), .arr_wr(arr_wr), .arr_wr_row(arr_wr_row),
        .ref_ack(ref_ack), .err(err_o), .row_open(row_open), .busy(busy)
    );

    dram_cell_array #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_array (
        .clk(clk), .rd_row(arr_rd_row), .rd_data(arr_rd_data),
        .wr_en(arr_wr), .wr_row(arr_wr_row), .wr_data(latches)
    );

    dram_col_latch #(.COL_BITS(COL_BITS)) u_latch (
        .clk(clk), .rst_n(rst_n), .load(lat_load), .load_data(arr_rd_data),
        .wr_en(lat_wr), .rd_en(lat_rd), .col(lat_col), .din(din_i),
        .latches(latches), .dout(dout_o), .dvalid(dvalid_o)
    );

    dram_ref_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .interval(ref_interval_i),
        .ack(ref_ack), .req(ref_req_o)
    );

endmodule

// File: rtl/dram_rowbuf_chk.sv
// Protocol checker for dram_rowbuf, attached by bind. Observes ports and
// the bank-open / busy status that the sequencer drives.
module dram_rowbuf_chk (
    input logic clk,
    input logic rst_n,
    input logic ras_i,
    input logic cas_i,
    input logic we_i,
    input logic nib_i,
    input logic pre_i,
    input logic ref_i,
    input logic dvalid_o,
    input logic err_o,
    input logic ref_req_o,
    input logic row_open,
    input logic busy
);
    logic col_ok, nib_go, wr_go, pre_go, ref_go;

    // Accepted-command terms seen from the ports.
    always_comb begin
        col_ok = cas_i && !ras_i && !pre_i && !ref_i && row_open && !busy;
        nib_go = col_ok && !we_i && nib_i;
        wr_go  = col_ok && we_i;
        pre_go = pre_i && !ref_i && row_open && !busy;
        ref_go = ref_i && !row_open && !busy;
    end

    // R4: a nibble read yields four consecutive valid cycles.
    a_r4_nibble_four: assert property (@(posedge clk) disable iff (!rst_n)
        nib_go |=> dvalid_o ##1 dvalid_o ##1 dvalid_o ##1 dvalid_o);

    // R2: a write produces no data-valid cycle.
    a_r2_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> !dvalid_o);

    // R6: precharge closes the bank.
    a_r6_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
        pre_go |=> !row_open);

    // R10: column strobe on a closed, idle bank flags an error.
    a_r10_closed_cas_err: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_i && !ras_i && !pre_i && !ref_i && !row_open && !busy) |=> (err_o && !dvalid_o));

    // R8: refresh request holds until a refresh is accepted.
    a_r8_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req_o && !ref_go) |=> ref_req_o);

    // R9: data is valid only when a row was open.
    a_r9_valid_needs_row: assert property (@(posedge clk) disable iff (!rst_n)
        dvalid_o |-> $past(row_open));

endmodule

bind dram_rowbuf dram_rowbuf_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ras_i(ras_i), .cas_i(cas_i), .we_i(we_i),
    .nib_i(nib_i), .pre_i(pre_i), .ref_i(ref_i), .dvalid_o(dvalid_o),
    .err_o(err_o), .ref_req_o(ref_req_o), .row_open(row_open), .busy(busy)
);

// File: tb/test_dram_rowbuf.sv
// Bench for dram_rowbuf: directed corners plus seeded random traffic,
// checked against a bench-side model of array and latches.
module test_dram_rowbuf;
    localparam int RB = 4;
    localparam int CB = 5;
    localparam int CW = 8;
    localparam int NR = 1 << RB;
    localparam int NC = 1 << CB;
    localparam int AW = (RB > CB) ? RB : CB;
    localparam int IVL = 20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ras = 0, cas = 0, we = 0, nib = 0, pre = 0, rf = 0, din = 0;
    logic [AW-1:0] addr = '0;
    logic [CW-1:0] ivl = IVL[CW-1:0];
    logic dout, dvalid, err, req;

    int checks = 0, fails = 0;
    logic [NC-1:0] m_arr [NR];
    logic [NC-1:0] m_lat;
    int m_row = 0;
    bit m_open = 0;

    always #4 clk = ~clk;

    dram_rowbuf #(.ROW_BITS(RB), .COL_BITS(CB), .CNT_W(CW)) i_dram_rowbuf (
        .clk(clk), .rst_n(rst_n), .ras_i(ras), .cas_i(cas), .we_i(we), .nib_i(nib),
        .pre_i(pre), .ref_i(rf), .addr_i(addr), .din_i(din), .ref_interval_i(ivl),
        .dout_o(dout), .dvalid_o(dvalid), .err_o(err), .ref_req_o(req)
    );

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // Nibble column sequence: low two bits wrap modulo 4.
    function automatic int nib_col(input int c, input int k);
        return (c & ~3) | ((c + k) & 3);
    endfunction

    // Drive one strobe set for one cycle; returns at the negedge after.
    task automatic issue(input bit r, c, w, n, p, f, input int a, input bit d);
        ras = r; cas = c; we = w; nib = n; pre = p; rf = f;
        addr = AW'(a); din = d;
        @(negedge clk);
        ras = 0; cas = 0; we = 0; nib = 0; pre = 0; rf = 0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic do_act(input int r);
        issue(1, 0, 0, 0, 0, 0, r, 0);
        m_lat = m_arr[r]; m_row = r; m_open = 1;
    endtask

    task automatic do_pre();
        issue(0, 0, 0, 0, 1, 0, 0, 0);
        m_arr[m_row] = m_lat; m_open = 0;
    endtask

    task automatic do_wr(input int c, input bit d);
        issue(0, 1, 1, 0, 0, 0, c, d);
        m_lat[c] = d;
        chk("R2 write dvalid", dvalid, 0);
    endtask

    task automatic do_rd(input string rq, input int c);
        issue(0, 1, 0, 0, 0, 0, c, 0);
        chk({rq, " dvalid"}, dvalid, 1);
        chk({rq, " data"}, dout, m_lat[c]);
    endtask

    task automatic do_nib(input int c);
        issue(0, 1, 0, 1, 0, 0, c, 0);
        for (int k = 0; k < 4; k++) begin
            chk("R4 nibble valid", dvalid, 1);
            chk("R4 nibble data", dout, m_lat[nib_col(c, k)]);
            if (k < 3) idle();
        end
        idle();
        chk("R9 after burst", dvalid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state.
        chk("R12 dvalid", dvalid, 0);
        chk("R12 dout", dout, 0);
        chk("R12 err", err, 0);
        chk("R12 req", req, 0);

        // Fill every bit with known data.
        for (int r = 0; r < NR; r++) begin
            do_act(r);
            for (int c = 0; c < NC; c++) do_wr(c, 1'($urandom));
            do_pre();
        end

        // R1 / R3: open a row and read several columns (page mode).
        do_act(3);
        do_rd("R1 read", 5);
        do_rd("R3 page", 0);
        do_rd("R3 page", NC - 1);
        // R10: row strobe while open.
        issue(1, 0, 0, 0, 0, 0, 7, 0);
        chk("R10 ras open err", err, 1);
        idle();
        chk("R10 err one cycle", err, 0);
        do_rd("R10 row kept", 5);
        // R2: write then read back.
        do_wr(5, ~m_lat[5]);
        do_rd("R2 readback", 5);
        // R4 / R5: nibble from mid-group, write during burst ignored.
        issue(0, 1, 0, 1, 0, 0, 6, 0);
        chk("R4 nib0 valid", dvalid, 1);
        chk("R4 nib0 data", dout, m_lat[6]);
        issue(0, 1, 1, 0, 0, 0, 7, ~m_lat[7]);
        chk("R4 nib1 data", dout, m_lat[7]);
        idle();
        chk("R4 nib2 wrap", dout, m_lat[4]);
        idle();
        chk("R4 nib3 data", dout, m_lat[5]);
        chk("R4 nib3 valid", dvalid, 1);
        idle();
        chk("R9 idle dvalid", dvalid, 0);
        do_rd("R5 burst write ignored", 7);
        do_nib(NC - 1);
        // R6: precharge then reopen.
        do_pre();
        do_act(3);
        do_rd("R6 reopen", 5);
        // R11: precharge and row together: precharge wins, row dropped.
        issue(1, 0, 0, 0, 1, 0, 9, 0);
        m_arr[m_row] = m_lat; m_open = 0;
        chk("R11 no err", err, 0);
        issue(0, 1, 0, 0, 0, 0, 2, 0);
        chk("R10 closed cas err", err, 1);
        chk("R10 closed cas dvalid", dvalid, 0);
        // R11: refresh with column while closed: column dropped.
        issue(0, 1, 0, 0, 0, 1, 2, 0);
        chk("R11 cas dropped", err, 0);
        idle();

        // R8 timing from an accepted refresh; R7 data unchanged.
        issue(0, 0, 0, 0, 0, 1, 7, 0);
        chk("R8 req cleared", req, 0);
        repeat (IVL - 1) idle();
        chk("R8 req before N", req, 0);
        idle();
        chk("R8 req at N", req, 1);
        do_act(7);
        for (int c = 0; c < NC; c += 3) do_rd("R7 refresh keeps", c);
        issue(0, 0, 0, 0, 0, 1, 7, 0);
        chk("R7 open refresh ignored", req, 1);
        do_rd("R7 row still open", 1);
        do_pre();
        ivl = '0;
        issue(0, 0, 0, 0, 0, 1, 2, 0);
        repeat (3 * IVL) idle();
        chk("R8 interval zero", req, 0);
        ivl = IVL[CW-1:0];

        // Random traffic.
        for (int i = 0; i < 1500; i++) begin
            int op = $urandom_range(0, 9);
            int c = $urandom_range(0, NC - 1);
            if (!m_open) begin
                if (op == 0) begin
                    issue(0, 1, 0, 0, 0, 0, c, 0);
                    chk("R10 rnd closed err", err, 1);
                end else if (op == 1) begin
                    issue(0, 0, 0, 0, 0, 1, $urandom_range(0, NR - 1), 0);
                    idle();
                end else begin
                    do_act($urandom_range(0, NR - 1));
                end
            end else begin
                if (op < 4)      do_rd("R3 rnd read", c);
                else if (op < 7) do_wr(c, 1'($urandom));
                else if (op < 8) do_nib(c);
                else             do_pre();
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule